// File: doc/BRIEF.md
# Sixteen-Line Interrupt Concentrator

This block collects interrupt requests from sixteen board peripherals and presents them to a host as one active-high level interrupt. Each source line is synchronized to the block clock. A rising edge on a synchronized line latches a pending bit, and that bit stays set until software acknowledges it by writing a one to it. A separate enable mask decides which pending bits may drive the combined interrupt. Software never writes the mask as a whole word. It sets enable bits through one address and clears them through another, and in both cases only the bits written as one are affected.

The host reaches the block over a simple 16-bit register bus with single-cycle write and read strobes. Read data is registered and is valid in the cycle after the read strobe. On an interrupt, the host reads the pending word and the enable mask, ANDs the two, and services each set bit. On the board, source 8 carries the Ethernet controller and sources 10 and 11 carry the two external UART channels. The block itself treats all sixteen lines the same way.

Top module: `irq_expander`

## Requirements
- R1: After a synchronous reset, the pending word, the enable mask and `irq_o` are all zero, and `bus_rdata` is zero.
- R2: A rising edge on `src_i[n]` sets pending bit n. The source must be low for at least two clocks before the edge and high for at least two clocks after it.
- R3: A pending bit stays set after its source goes low again. Only an acknowledge clears it.
- R4: A write to byte offset 0x16 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value. A read of 0x16 returns the pending word, with bit n for source n.
- R5: When a new rising edge on a source and an acknowledge of that same bit fall in the same clock, the bit ends up set.
- R6: A write to offset 0x1A sets each enable bit whose data bit is 1. A write to offset 0x1C clears each enable bit whose data bit is 1. Enable bits whose data bit is 0 are unchanged in both cases.
- R7: Reads of offset 0x1A and of offset 0x1C both return the current enable mask.
- R8: A read of offset 0x18 returns the synchronized levels of the sixteen source inputs, not the latched pending bits.
- R9: `irq_o` is high exactly when the bitwise AND of the pending word and the enable mask was nonzero in the previous clock.
- R10: Writes to offset 0x18 or to any unmapped offset change no state. Reads of unmapped offsets return zero.
- R11: Writing 0xFFFF to offset 0x1C and then 0xFFFF to offset 0x16 leaves every source disabled, nothing pending, and `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 16 | Asynchronous interrupt request levels, bit n for source n |
| bus_addr | input | 5 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, one clock per read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the clock after `bus_rd`, zero otherwise |
| irq_o | output | 1 | Combined level interrupt, active high |

## Verification
The hardest case to reach from the ports is the race between a fresh edge and an acknowledge of the same bit. The acknowledge write has to land on exactly the clock where the synchronized edge reaches the pending register, which is two clocks after the input rises. The stimulus raises a source on a falling edge, waits two more falling edges, and presents the acknowledge in that slot. The same write also acknowledges a different, already-pending bit, so one access shows both outcomes. A behavioural model that tracks the synchronizer delay is compared against `irq_o` and `bus_rdata` on every clock, and it catches any shift of this slot by one cycle.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  // Byte offsets of the register window. The host software decodes these.
  localparam int unsigned OFF_PEND  = 'h16;
  localparam int unsigned OFF_LIVE  = 'h18;
  localparam int unsigned OFF_ENSET = 'h1A;
  localparam int unsigned OFF_ENCLR = 'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_LIVE,
    SEL_ENSET,
    SEL_ENCLR
  } reg_sel_e;
endpackage

// File: rtl/irqx_sync.sv
module irqx_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irqx_pend.sv
module irqx_pend #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] pend_q;

  assign rise_o = level_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= level_i;
      // a new edge overrides an acknowledge in the same clock
      pend_q <= (pend_q & ~ack_i) | rise_o;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqx_enable.sv
module irqx_enable #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= (en_q | set_i) & ~clr_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/irq_expander.sv
module irq_expander #(
  parameter int N_SRC       = 16,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  output logic              irq_o
);
  import irqx_pkg::*;

  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_LIVE  = ADDR_W'(OFF_LIVE);
  localparam logic [ADDR_W-1:0] A_ENSET = ADDR_W'(OFF_ENSET);
  localparam logic [ADDR_W-1:0] A_ENCLR = ADDR_W'(OFF_ENCLR);

  reg_sel_e         sel;
  logic [N_SRC-1:0] live_w, rise_w, pend_w, en_w;
  logic [N_SRC-1:0] ack_w, set_w, clr_w;
  logic [N_SRC-1:0] rdata_q, rd_mux;
  logic             irq_q;

  always_comb begin
    unique case (bus_addr)
      A_PEND:  sel = SEL_PEND;
      A_LIVE:  sel = SEL_LIVE;
      A_ENSET: sel = SEL_ENSET;
      A_ENCLR: sel = SEL_ENCLR;
      default: sel = SEL_NONE;
    endcase
  end

  assign ack_w = (bus_wr && sel == SEL_PEND)  ? bus_wdata : '0;
  assign set_w = (bus_wr && sel == SEL_ENSET) ? bus_wdata : '0;
  assign clr_w = (bus_wr && sel == SEL_ENCLR) ? bus_wdata : '0;

  irqx_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(src_i), .sync_o(live_w)
  );

  irqx_pend #(.W(N_SRC)) u_pend (
    .clk(clk), .rst(rst), .level_i(live_w), .ack_i(ack_w),
    .rise_o(rise_w), .pend_o(pend_w)
  );

  irqx_enable #(.W(N_SRC)) u_en (
    .clk(clk), .rst(rst), .set_i(set_w), .clr_i(clr_w), .en_o(en_w)
  );

  always_comb begin
    unique case (sel)
      SEL_PEND:             rd_mux = pend_w;
      SEL_LIVE:             rd_mux = live_w;
      SEL_ENSET, SEL_ENCLR: rd_mux = en_w;
      default:              rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= bus_rd ? rd_mux : '0;
      irq_q   <= |(pend_w & en_w);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/irqx_checker.sv
module irqx_checker #(
  parameter int N  = 16,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [N-1:0]  bus_wdata,
  input logic [N-1:0]  rise,
  input logic [N-1:0]  pend,
  input logic [N-1:0]  mask,
  input logic          irq_o
);
  localparam logic [AW-1:0] A_PEND  = AW'(irqx_pkg::OFF_PEND);
  localparam logic [AW-1:0] A_ENSET = AW'(irqx_pkg::OFF_ENSET);
  localparam logic [AW-1:0] A_ENCLR = AW'(irqx_pkg::OFF_ENCLR);

  logic wr_pend, wr_set, wr_clr, wr_other;
  assign wr_pend  = bus_wr && bus_addr == A_PEND;
  assign wr_set   = bus_wr && bus_addr == A_ENSET;
  assign wr_clr   = bus_wr && bus_addr == A_ENCLR;
  assign wr_other = bus_wr && !wr_pend && !wr_set && !wr_clr;

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_o == 1'b0 && mask == '0 && pend == '0));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_pend) |-> (($past(pend) & ~pend) == '0));

  a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
    $past(wr_pend) |-> ((pend & $past(bus_wdata) & ~$past(rise)) == '0));

  a_r5_edge_wins: assert property (@(posedge clk) disable iff (rst)
    (|rise) |=> ((pend & $past(rise)) == $past(rise)));

  a_r6_set: assert property (@(posedge clk) disable iff (rst)
    $past(wr_set) |-> ((mask & $past(bus_wdata)) == $past(bus_wdata)));

  a_r6_clr: assert property (@(posedge clk) disable iff (rst)
    $past(wr_clr) |-> ((mask & $past(bus_wdata)) == '0));

  a_r9_level: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past(|(pend & mask)));

  a_r10_ignored: assert property (@(posedge clk) disable iff (rst)
    $past(wr_other) |-> $stable(mask));
endmodule

bind irq_expander irqx_checker #(.N(N_SRC), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rise(rise_w), .pend(pend_w), .mask(en_w),
  .irq_o(irq_o)
);

// File: tb/irq_expander_tb.sv
module irq_expander_tb_top;
  localparam int N = 16;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  src = '0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          irq;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  irq_expander dut_i (
    .clk(clk), .rst(rst), .src_i(src), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  // behavioural reference model
  logic [N-1:0] m_s1, m_live, m_prev, m_pend, m_en, m_rdata;
  logic         m_irq;

  always @(posedge clk) begin
    logic [N-1:0] rise, nrd;
    if (rst) begin
      m_s1 = '0; m_live = '0; m_prev = '0; m_pend = '0; m_en = '0;
      m_rdata = '0; m_irq = 0;
    end else begin
      rise = m_live & ~m_prev;
      nrd = '0;
      if (rd) begin
        if (addr == 5'h16) nrd = m_pend;
        else if (addr == 5'h18) nrd = m_live;
        else if (addr == 5'h1A || addr == 5'h1C) nrd = m_en;
      end
      m_irq = (m_pend & m_en) != '0;
      m_rdata = nrd;
      if (wr && addr == 5'h16) m_pend = m_pend & ~wdata;
      m_pend = m_pend | rise;
      if (wr && addr == 5'h1A) m_en = m_en | wdata;
      if (wr && addr == 5'h1C) m_en = m_en & ~wdata;
      m_prev = m_live;
      m_live = m_s1;
      m_s1 = src;
    end
  end

  task automatic check(string req, logic [N-1:0] got, logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R9 irq vs model", {15'b0, irq}, {15'b0, m_irq});
      check("R7 readback vs model", rdata, m_rdata);
    end
  end

  task automatic bus_write(logic [AW-1:0] a, logic [N-1:0] d);
    addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0; wdata = '0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [N-1:0] d);
    addr = a; rd = 1;
    @(negedge clk);
    rd = 0;
    d = rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog expired got=%0d expected=<20000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [N-1:0] v;
    idle(4);
    rst = 0;
    @(negedge clk);
    check("R1 irq after reset", {15'b0, irq}, '0);
    check("R1 rdata after reset", rdata, '0);
    bus_read(5'h16, v); check("R1 pending after reset", v, '0);
    bus_read(5'h1A, v); check("R1 mask after reset", v, '0);

    // R2/R3: pulse source 8 (Ethernet), then let it fall
    src[8] = 1; idle(3); src[8] = 0; idle(4);
    bus_read(5'h16, v); check("R2 R3 pending bit 8 latched and held", v, 16'h0100);
    check("R9 irq low while masked", {15'b0, irq}, '0);

    // R8: raw level readback
    bus_read(5'h18, v); check("R8 raw levels idle", v, 16'h0000);
    src[10] = 1; idle(3);
    bus_read(5'h18, v); check("R8 raw level of source 10", v, 16'h0400);

    // R6/R7 enable set/clear
    bus_write(5'h1A, 16'h0100);
    bus_read(5'h1A, v); check("R6 set enable 8", v, 16'h0100);
    bus_read(5'h1C, v); check("R7 clear offset reads mask", v, 16'h0100);
    idle(1);
    check("R9 irq high when enabled and pending", {15'b0, irq}, 16'h0001);
    bus_write(5'h1A, 16'h0C00);
    bus_read(5'h1A, v); check("R6 zeros leave enable unchanged", v, 16'h0D00);
    bus_write(5'h1C, 16'h0100);
    bus_read(5'h1C, v); check("R6 clear enable 8", v, 16'h0C00);

    // R4 acknowledge
    bus_read(5'h16, v); check("R2 pending 8 and 10", v, 16'h0500);
    bus_write(5'h16, 16'h0400);
    bus_read(5'h16, v); check("R4 ack clears only bit 10", v, 16'h0100);
    idle(1);
    check("R9 irq low after ack", {15'b0, irq}, '0);

    // R5 edge in the same clock as acknowledge
    src[11] = 1;
    idle(2);
    bus_write(5'h16, 16'h0900);
    bus_read(5'h16, v); check("R5 edge beats ack, bit 8 cleared", v, 16'h0800);
    idle(1);
    check("R9 irq from source 11", {15'b0, irq}, 16'h0001);

    // R10 ignored writes, unmapped reads
    bus_write(5'h18, 16'hFFFF);
    bus_write(5'h00, 16'hFFFF);
    bus_write(5'h1E, 16'hFFFF);
    bus_read(5'h1A, v); check("R10 mask unchanged", v, 16'h0C00);
    bus_read(5'h16, v); check("R10 pending unchanged", v, 16'h0800);
    bus_read(5'h00, v); check("R10 unmapped read zero", v, '0);
    bus_read(5'h1E, v); check("R10 unmapped read zero hi", v, '0);

    // R11 full quiesce sequence
    bus_write(5'h1C, 16'hFFFF);
    bus_write(5'h16, 16'hFFFF);
    bus_read(5'h1A, v); check("R11 all disabled", v, '0);
    bus_read(5'h16, v); check("R11 nothing pending", v, '0);
    idle(2);
    check("R11 irq low", {15'b0, irq}, '0);

    finish_run();
  end
endmodule